// File: doc/BRIEF.md
# Indirect Register Access Bridge

This block lets a 32-bit memory-mapped host reach an 8-bit peripheral register space that is not mapped onto the host bus directly. The host loads a command word that carries the target byte address, the transfer direction, a size flag and byte enables. It then either launches a read with that command write, or it writes the data register, which launches a write. A busy flag in the command word stays high while the peripheral is working, and the host polls it until it clears. After a read, the lower data register holds the returned byte.

The bridge also gathers two interrupt sources into a flag register and an enable register. One source is a pulse from the peripheral subsystem. The other is the end of each bridge transfer. In this block, the peripheral is modelled as a 256-entry byte register file with a fixed, parameterised latency. Host reads are combinational on the offset. Host writes take effect on the clock edge at which they are presented.

Top module: `ind_reg_bridge`

## Requirements
- R1: After reset, the command, lower data, interrupt enable and interrupt flag registers read 0, `irq_o` is low and busy (command bit 31) is 0. Offset 0x00 always reads the `ID_VALUE` parameter.
- R2: A write to the command register at offset 0x04 stores bits 25 (size), 24 (direction, 1 = read), 23:20 (upper enables), 19:16 (lower enables) and 7:0 (peripheral address). All other bits read 0, and bit 31 reads the live busy flag.
- R3: A write to the lower data register at offset 0x08 while the stored direction is 0 launches a peripheral write. Busy is high from the edge of that host write for exactly `LATENCY` cycles.
- R4: A command write with bit 24 set launches a read of the addressed peripheral byte. When busy falls, the lower data register holds that byte in bits 7:0 and zeros above.
- R5: While busy is high, writes to the command register and the lower data register are ignored and launch nothing.
- R6: Only byte 0, gated by lower enable bit 16, reaches the peripheral. If bit 16 is clear, a write leaves the peripheral register unchanged and a read returns 0. Data register bytes whose lower enable bit is clear read back 0.
- R7: A one-cycle pulse on `sub_irq_i` sets flag bit 1 (offset 0x14). Completion of any transfer sets flag bit 0.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If a set and a clear of the same bit fall in the same cycle, the bit ends up set.
- R9: `irq_o` is high exactly when some flag bit and the matching bit of the enable register (offset 0x10, bits 1:0) are both 1.
- R10: The upper data register at offset 0x0C and unmapped offsets read 0. Writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| host_we_i | input | 1 | Host write strobe, one cycle per write |
| host_addr_i | input | HADDR_W | Host byte offset |
| host_wdata_i | input | 32 | Host write data |
| host_rdata_o | output | 32 | Host read data for `host_addr_i` |
| sub_irq_i | input | 1 | Subsystem interrupt pulse |
| irq_o | output | 1 | Combined interrupt request |

## Verification
On every cycle, the assertions check the following. The command and data registers hold still while busy is high. A transfer never starts while another is in flight. Busy drops right after the completion cycle. A subsystem pulse always leaves flag bit 1 set, even against a same-cycle clear. `irq_o` is never high without a flag and an enable. Only the bench scenarios can show the rest: the exact length of the busy window, the byte that returns from the peripheral, the effect of clear enables on peripheral contents, command field masking, and the zero readback of the upper data and unmapped offsets.

// File: rtl/ind_bridge_pkg.sv
`timescale 1ns/1ps
package ind_bridge_pkg;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned PADDR_W = 8;
  localparam int unsigned PDATA_W = 8;

  localparam logic [4:0] OFS_ID   = 5'h00;
  localparam logic [4:0] OFS_CMD  = 5'h04;
  localparam logic [4:0] OFS_LDAT = 5'h08;
  localparam logic [4:0] OFS_UDAT = 5'h0C;
  localparam logic [4:0] OFS_IEN  = 5'h10;
  localparam logic [4:0] OFS_IFLG = 5'h14;

  localparam int unsigned CMD_BUSY = 31;
  localparam int unsigned CMD_DIR  = 24;
  localparam int unsigned CMD_BEN0 = 16;
  localparam logic [31:0] CMD_MASK = 32'h03FF_00FF;

  function automatic logic [31:0] byte_mask(input logic [3:0] ben);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[b*8 +: 8] = {8{ben[b]}};
    return m;
  endfunction
endpackage

// File: rtl/ind_periph_model.sv
`timescale 1ns/1ps
module ind_periph_model #(
  parameter int unsigned LATENCY = 4,
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ben_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          rd_done_o,
  output logic [DW-1:0] rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;
  localparam int unsigned CW = $clog2(LATENCY + 1);

  logic [CW-1:0] cnt_q;
  logic          we_q, ben_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic [DW-1:0] mem_q [DEPTH];

  assign busy_o    = (cnt_q != '0);
  assign done_o    = (cnt_q == CW'(1));
  assign rd_done_o = done_o && !we_q;
  assign rdata_o   = ben_q ? mem_q[addr_q] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      we_q    <= 1'b0;
      ben_q   <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (start_i && !busy_o) begin
      cnt_q   <= CW'(LATENCY);
      we_q    <= we_i;
      ben_q   <= ben_i;
      addr_q  <= addr_i;
      wdata_q <= wdata_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (done_o && we_q && ben_q) begin
      mem_q[addr_q] <= wdata_q;
    end
  end

  assert_no_restart_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_o);
  assert_done_ends_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
endmodule

// File: rtl/ind_irq_unit.sv
`timescale 1ns/1ps
module ind_irq_unit #(
  parameter int unsigned NSRC = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] set_i,
  input  logic            en_we_i,
  input  logic            flg_we_i,
  input  logic [NSRC-1:0] wdata_i,
  output logic [NSRC-1:0] en_o,
  output logic [NSRC-1:0] flg_o,
  output logic            irq_o
);
  logic [NSRC-1:0] en_q, flg_q, clr;

  assign clr   = flg_we_i ? wdata_i : '0;
  assign en_o  = en_q;
  assign flg_o = flg_q;
  assign irq_o = |(flg_q & en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= '0;
      flg_q <= '0;
    end else begin
      if (en_we_i) en_q <= wdata_i;
      flg_q <= (flg_q & ~clr) | set_i; // set wins
    end
  end

  assert_set_wins_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i[NSRC-1] |=> flg_q[NSRC-1]);
  assert_irq_src_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (flg_q != '0 && en_q != '0));
endmodule

// File: rtl/ind_xfer_ctrl.sv
`timescale 1ns/1ps
module ind_xfer_ctrl
  import ind_bridge_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_we_i,
  input  logic               dat_we_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               busy_i,
  input  logic               rd_done_i,
  input  logic [PDATA_W-1:0] rdata_i,
  output logic               start_o,
  output logic               p_we_o,
  output logic [PADDR_W-1:0] p_addr_o,
  output logic [PDATA_W-1:0] p_wdata_o,
  output logic               p_ben_o,
  output logic [DATA_W-1:0]  cmd_o,
  output logic [DATA_W-1:0]  ldata_o
);
  logic [DATA_W-1:0] cmd_q, ldata_q;
  logic rd_go, wr_go;

  assign rd_go = cmd_we_i && !busy_i && wdata_i[CMD_DIR];
  assign wr_go = dat_we_i && !busy_i && !cmd_q[CMD_DIR];

  assign start_o   = rd_go || wr_go;
  assign p_we_o    = wr_go;
  assign p_addr_o  = rd_go ? wdata_i[PADDR_W-1:0] : cmd_q[PADDR_W-1:0];
  assign p_ben_o   = rd_go ? wdata_i[CMD_BEN0] : cmd_q[CMD_BEN0];
  assign p_wdata_o = wdata_i[PDATA_W-1:0];

  assign cmd_o   = cmd_q | (DATA_W'(busy_i) << CMD_BUSY);
  assign ldata_o = ldata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q   <= '0;
      ldata_q <= '0;
    end else begin
      if (cmd_we_i && !busy_i) cmd_q <= wdata_i & CMD_MASK;
      if (dat_we_i && !busy_i)
        ldata_q <= wdata_i & byte_mask(cmd_q[CMD_BEN0 +: 4]);
      else if (rd_done_i)
        ldata_q <= DATA_W'(rdata_i);
    end
  end

  assert_cmd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(cmd_q));
  assert_ldata_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !rd_done_i) |=> $stable(ldata_q));
endmodule

// File: rtl/ind_reg_bridge.sv
`timescale 1ns/1ps
module ind_reg_bridge
  import ind_bridge_pkg::*;
#(
  parameter int unsigned HADDR_W = 5,
  parameter int unsigned LATENCY = 4,
  parameter logic [31:0] ID_VALUE = 32'h4952_0001
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               host_we_i,
  input  logic [HADDR_W-1:0] host_addr_i,
  input  logic [31:0]        host_wdata_i,
  output logic [31:0]        host_rdata_o,
  input  logic               sub_irq_i,
  output logic               irq_o
);
  localparam int unsigned NSRC = 2;

  logic [4:0] ofs;
  logic cmd_we, dat_we, ien_we, iflg_we;
  logic start, p_we, p_ben, busy, done, rd_done;
  logic [PADDR_W-1:0] p_addr;
  logic [PDATA_W-1:0] p_wdata, p_rdata;
  logic [DATA_W-1:0] cmd, ldata;
  logic [NSRC-1:0] ien, iflg;

  assign ofs     = 5'(host_addr_i);
  assign cmd_we  = host_we_i && ofs == OFS_CMD;
  assign dat_we  = host_we_i && ofs == OFS_LDAT;
  assign ien_we  = host_we_i && ofs == OFS_IEN;
  assign iflg_we = host_we_i && ofs == OFS_IFLG;

  ind_xfer_ctrl u_ctrl (
    .clk_i, .rst_ni,
    .cmd_we_i(cmd_we), .dat_we_i(dat_we), .wdata_i(host_wdata_i),
    .busy_i(busy), .rd_done_i(rd_done), .rdata_i(p_rdata),
    .start_o(start), .p_we_o(p_we), .p_addr_o(p_addr),
    .p_wdata_o(p_wdata), .p_ben_o(p_ben),
    .cmd_o(cmd), .ldata_o(ldata)
  );

  ind_periph_model #(.LATENCY(LATENCY), .AW(PADDR_W), .DW(PDATA_W)) u_periph (
    .clk_i, .rst_ni,
    .start_i(start), .we_i(p_we), .addr_i(p_addr), .wdata_i(p_wdata),
    .ben_i(p_ben), .busy_o(busy), .done_o(done), .rd_done_o(rd_done),
    .rdata_o(p_rdata)
  );

  ind_irq_unit #(.NSRC(NSRC)) u_irq (
    .clk_i, .rst_ni,
    .set_i({sub_irq_i, done}), .en_we_i(ien_we), .flg_we_i(iflg_we),
    .wdata_i(host_wdata_i[NSRC-1:0]),
    .en_o(ien), .flg_o(iflg), .irq_o(irq_o)
  );

  always_comb begin
    unique case (ofs)
      OFS_ID:   host_rdata_o = ID_VALUE;
      OFS_CMD:  host_rdata_o = cmd;
      OFS_LDAT: host_rdata_o = ldata;
      OFS_IEN:  host_rdata_o = 32'(ien);
      OFS_IFLG: host_rdata_o = 32'(iflg);
      default:  host_rdata_o = '0;
    endcase
  end
endmodule

// File: tb/ind_reg_bridge_bench.sv
`timescale 1ns/1ps
module ind_reg_bridge_bench;
  localparam int LAT = 4;
  localparam logic [31:0] ID = 32'h4952_0001;

  logic clk = 0, rst_n = 0, we = 0, sub_irq = 0, irq;
  logic [4:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  ind_reg_bridge #(.HADDR_W(5), .LATENCY(LAT), .ID_VALUE(ID)) u_ind_reg_bridge (
    .clk_i(clk), .rst_ni(rst_n), .host_we_i(we), .host_addr_i(addr),
    .host_wdata_i(wdata), .host_rdata_o(rdata), .sub_irq_i(sub_irq), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [4:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic hr(input logic [4:0] a, output logic [31:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic wait_idle(output int n);
    logic [31:0] c;
    n = 0;
    hr(5'h04, c);
    while (c[31] && n < 100) begin
      n++; @(negedge clk); hr(5'h04, c);
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    hr(5'h00, v); chk("R1 id", v, ID);
    hr(5'h04, v); chk("R1 cmd", v, 0);
    hr(5'h08, v); chk("R1 ldata", v, 0);
    hr(5'h10, v); chk("R1 ien", v, 0);
    hr(5'h14, v); chk("R1 iflg", v, 0);
    chk("R1 irq", 32'(irq), 0);
  endtask

  task automatic t_cmd_fields();
    logic [31:0] v;
    hw(5'h04, 32'hFEF5_FF5A);
    hr(5'h04, v); chk("R2 cmd mask", v, 32'h02F5_005A);
  endtask

  task automatic t_write_read();
    logic [31:0] v; int n;
    hw(5'h14, 32'h3);
    hw(5'h04, 32'h0001_0010);
    hw(5'h08, 32'h1234_56C3);
    hr(5'h04, v); chk("R3 busy rises", 32'(v[31]), 1);
    hr(5'h08, v); chk("R6 ldata masked", v, 32'h0000_00C3);
    wait_idle(n); chk("R3 busy length", 32'(n), LAT);
    hr(5'h14, v); chk("R7 done flag", v, 32'h1);
    hw(5'h04, 32'h0101_0010);
    wait_idle(n); chk("R4 read busy length", 32'(n), LAT);
    hr(5'h08, v); chk("R4 read data", v, 32'h0000_00C3);
  endtask

  task automatic t_ignore_busy();
    logic [31:0] v; int n;
    hw(5'h04, 32'h0101_0010);
    hw(5'h04, 32'h0001_0020);
    hw(5'h08, 32'h0000_00AA);
    wait_idle(n);
    hr(5'h04, v); chk("R5 cmd held", v, 32'h0101_0010);
    hr(5'h08, v); chk("R5 ldata held", v, 32'h0000_00C3);
    hw(5'h04, 32'h0101_0020);
    wait_idle(n);
    hr(5'h08, v); chk("R5 no write to 0x20", v, 0);
  endtask

  task automatic t_ben();
    logic [31:0] v; int n;
    hw(5'h04, 32'h0002_0010);
    hw(5'h08, 32'h0000_7E11);
    hr(5'h08, v); chk("R6 only byte1 kept", v, 32'h0000_7E00);
    wait_idle(n);
    hw(5'h04, 32'h0101_0010);
    wait_idle(n);
    hr(5'h08, v); chk("R6 periph unchanged", v, 32'h0000_00C3);
    hw(5'h04, 32'h0100_0010);
    wait_idle(n);
    hr(5'h08, v); chk("R6 read no enable", v, 0);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    hw(5'h14, 32'h3);
    hr(5'h14, v); chk("R8 w1c", v, 0);
    sub_irq = 1; @(negedge clk); sub_irq = 0;
    hr(5'h14, v); chk("R7 sub flag", v, 32'h2);
    chk("R9 irq masked", 32'(irq), 0);
    hw(5'h10, 32'hFFFF_FFFE);
    hr(5'h10, v); chk("R9 ien bits", v, 32'h2);
    chk("R9 irq on", 32'(irq), 1);
    hw(5'h14, 32'h0);
    hr(5'h14, v); chk("R8 write 0 keeps", v, 32'h2);
    hw(5'h14, 32'h2);
    chk("R9 irq off after clear", 32'(irq), 0);
    sub_irq = 1; hw(5'h14, 32'h2); sub_irq = 0;
    hr(5'h14, v); chk("R8 set wins", v, 32'h2);
    hw(5'h14, 32'h2);
    hw(5'h10, 32'h1);
    chk("R9 irq flag1 not enabled", 32'(irq), 0);
  endtask

  task automatic t_misc();
    logic [31:0] v;
    hw(5'h0C, 32'hFFFF_FFFF);
    hr(5'h0C, v); chk("R10 upper zero", v, 0);
    hw(5'h18, 32'hFFFF_FFFF);
    hr(5'h18, v); chk("R10 unmapped", v, 0);
    hr(5'h00, v); chk("R10 id const", v, ID);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_cmd_fields();
    t_write_read();
    t_ignore_busy();
    t_ben();
    t_irq();
    t_misc();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule